// File: doc/BRIEF.md
# Processing-Node Multiply-Accumulate Datapath

This block is the arithmetic core of one node in a lock-step SIMD array. Every cycle the sequencer hands all nodes the same decoded instruction and the same broadcast word. Each node pairs that broadcast value with an operand fetched from its own 4 KB byte-addressed local memory. The two are multiplied, and the product joins a 32-bit running sum one cycle later. In the same cycle, a 12-bit address adder steps the node's private memory pointer by the instruction's offset.

A 32-entry by 16-bit register file moves data in both directions. Broadcast values or memory words and bytes can be loaded into it, and its contents can be stored back to memory as bytes or words. Each node can skip an instruction according to the zero and sign state of its own sum. This is how nodes running the same program follow different data-dependent paths. A global spin input from the sequencer freezes every node completely, including a product still waiting to be accumulated.

Top module: `simd_node_mac`

## Requirements
- R1: While reset is held, and once it is released, the sum reads 0, the pointer reads 0, the zero flag reads 1 and the sign flag reads 0.
- R2: Operation codes are 0 no-op, 1 word multiply-accumulate, 2 byte multiply-accumulate, 3 word load, 4 byte load, 5 word store, 6 byte store, 7 clear sum, 8 set pointer, 9 broadcast-to-register, and 10 to 15 no-op. For a word multiply-accumulate, bits 8:0 of the broadcast input are taken as signed and multiplied by the signed memory word at the pointer. The product is registered at the instruction's clock edge and is added to the sum, modulo 2^32, at the next edge.
- R3: A byte multiply-accumulate uses the byte at the exact pointer address, sign-extended, as the memory operand.
- R4: Codes 1 to 6 advance the pointer by the 12-bit offset, modulo 4096, at the instruction's edge. Code 8 loads the pointer with the offset.
- R5: A word access ignores pointer bit 0. Its low byte sits at the even address and its high byte at the odd address. mem_o always shows that word for the current pointer.
- R6: A byte load zero-extends the addressed byte into the destination register. A byte store writes bits 7:0 of the source register to the addressed byte only.
- R7: The register file has 32 entries of 16 bits. Codes 3, 4 and 9 write register rd_i. Stores read register rs_i. reg_o shows register rs_i.
- R8: Clear sets the sum to 0 and discards a product still waiting to be added.
- R9: The zero and sign flags are updated whenever the sum is written, and always equal (sum == 0) and sum bit 31.
- R10: The condition field selects 0 always, 1 if zero, 2 if negative, 3 if not zero, judged on the flags before the edge. A failed condition makes the instruction change no register, memory byte, pointer or sum, and issue no product. A product from an earlier instruction is still added.
- R11: While spin_i is 1, no state changes, including a product waiting to be added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| rs_i | input | 5 | Source register select |
| rd_i | input | 5 | Destination register select |
| cond_i | input | 2 | Execution condition |
| addr_off_i | input | 12 | Pointer offset or new pointer value |
| bcast_i | input | 16 | Broadcast operand from the input bus |
| spin_i | input | 1 | Global ignore from the sequencer |
| acc_o | output | 32 | Running sum |
| zero_o | output | 1 | Sum is zero |
| neg_o | output | 1 | Sum is negative |
| ptr_o | output | 12 | Local memory pointer |
| reg_o | output | 16 | Register rs_i |
| mem_o | output | 16 | Memory word at the pointer |

## Verification
Some properties are checked on every cycle. These are: the flags track the sum, spin freezes the sum, pointer and flags, clear empties the sum, the pointer steps or loads as ordered, and a failed zero condition leaves the pointer in place. The one-cycle lag between multiply and accumulate, signed operand extension, byte placement within words, and interactions such as a clear landing on a pending product can only be shown by the bench's reference model. The bench checks these in directed sequences and in a long mixed run.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MAC16 = 4'd1,
    OP_MAC8  = 4'd2,
    OP_LDW   = 4'd3,
    OP_LDB   = 4'd4,
    OP_STW   = 4'd5,
    OP_STB   = 4'd6,
    OP_CLR   = 4'd7,
    OP_SETP  = 4'd8,
    OP_MOVB  = 4'd9
  } node_op_e;

  typedef enum logic [1:0] {
    CC_ALWAYS  = 2'd0,
    CC_ZERO    = 2'd1,
    CC_NEG     = 2'd2,
    CC_NONZERO = 2'd3
  } node_cc_e;
endpackage

// File: rtl/node_regfile.sv
module node_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [SEL_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/node_local_mem.sv
module node_local_mem #(
  parameter int BYTES  = 4096,
  parameter int ADDR_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_word_i,
  input  logic              wr_byte_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       word_o,
  output logic [7:0]        byte_o
);
  localparam int ROWS = BYTES / 2;

  logic [ADDR_W-2:0] row;
  logic [7:0]        rd_bank [2];

  assign row = addr_i[ADDR_W-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] cells [ROWS];
    logic       wen;
    logic [7:0] wbyte;

    assign wen   = wr_word_i || (wr_byte_i && (addr_i[0] == 1'(b)));
    assign wbyte = wr_word_i ? wdata_i[8*b +: 8] : wdata_i[7:0];

    always_ff @(posedge clk) begin
      if (wen) cells[row] <= wbyte;
    end

    assign rd_bank[b] = cells[row];
  end

  assign word_o = {rd_bank[1], rd_bank[0]};
  assign byte_o = addr_i[0] ? rd_bank[1] : rd_bank[0];
endmodule

// File: rtl/node_addr_gen.sv
module node_addr_gen #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)     ptr_d = off_i;
    else if (adv_i) ptr_d = ptr_q + off_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/node_mult_acc.sv
module node_mult_acc #(
  parameter int A_W   = 9,
  parameter int B_W   = 16,
  parameter int ACC_W = 32,
  parameter int P_W   = A_W + B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             issue_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             zero_o,
  output logic             neg_o
);
  logic [P_W-1:0]   a_ext, b_ext, prod_full;
  logic [P_W-1:0]   prod_q, prod_d;
  logic             pv_q, pv_d;
  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             z_q, z_d, n_q, n_d;

  assign a_ext     = {{(P_W-A_W){a_i[A_W-1]}}, a_i};
  assign b_ext     = {{(P_W-B_W){b_i[B_W-1]}}, b_i};
  assign prod_full = a_ext * b_ext;
  assign sum       = acc_q + {{(ACC_W-P_W){prod_q[P_W-1]}}, prod_q};

  always_comb begin
    acc_d  = acc_q;
    z_d    = z_q;
    n_d    = n_q;
    pv_d   = pv_q;
    prod_d = prod_q;
    if (!hold_i) begin
      if (clr_i) begin
        acc_d = '0;
        z_d   = 1'b1;
        n_d   = 1'b0;
        pv_d  = 1'b0;
      end else begin
        if (pv_q) begin
          acc_d = sum;
          z_d   = (sum == '0);
          n_d   = sum[ACC_W-1];
        end
        pv_d = issue_i;
        if (issue_i) prod_d = prod_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      z_q    <= 1'b1;
      n_q    <= 1'b0;
      pv_q   <= 1'b0;
      prod_q <= '0;
    end else begin
      acc_q  <= acc_d;
      z_q    <= z_d;
      n_q    <= n_d;
      pv_q   <= pv_d;
      prod_q <= prod_d;
    end
  end

  assign acc_o  = acc_q;
  assign zero_o = z_q;
  assign neg_o  = n_q;
endmodule

// File: rtl/simd_node_mac.sv
module simd_node_mac
  import simd_mac_pkg::*;
#(
  parameter int MEM_BYTES = 4096,
  parameter int REGS      = 32,
  parameter int WORD_W    = 16,
  parameter int BC_MUL_W  = 9,
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = $clog2(MEM_BYTES),
  parameter int SEL_W     = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [SEL_W-1:0]  rs_i,
  input  logic [SEL_W-1:0]  rd_i,
  input  logic [1:0]        cond_i,
  input  logic [ADDR_W-1:0] addr_off_i,
  input  logic [WORD_W-1:0] bcast_i,
  input  logic              spin_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [WORD_W-1:0] reg_o,
  output logic [WORD_W-1:0] mem_o
);
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  node_op_e          op;
  logic              cond_ok, exec;
  logic              is_mac, adv, load_ptr;
  logic              reg_we, clr;
  logic [WORD_W-1:0] reg_wdata, rs_data, mem_word, mul_b;
  logic [7:0]        mem_byte;

  assign op = node_op_e'(op_i);

  always_comb begin
    unique case (node_cc_e'(cond_i))
      CC_ALWAYS:  cond_ok = 1'b1;
      CC_ZERO:    cond_ok = zero_o;
      CC_NEG:     cond_ok = neg_o;
      CC_NONZERO: cond_ok = !zero_o;
      default:    cond_ok = 1'b0;
    endcase
  end

  assign exec     = !spin_i && cond_ok;
  assign is_mac   = (op == OP_MAC16) || (op == OP_MAC8);
  assign adv      = exec && (op inside {OP_MAC16, OP_MAC8, OP_LDW, OP_LDB, OP_STW, OP_STB});
  assign load_ptr = exec && (op == OP_SETP);
  assign clr      = exec && (op == OP_CLR);
  assign reg_we   = exec && (op inside {OP_LDW, OP_LDB, OP_MOVB});

  always_comb begin
    unique case (op)
      OP_LDW:  reg_wdata = mem_word;
      OP_LDB:  reg_wdata = {{(WORD_W-8){1'b0}}, mem_byte};
      default: reg_wdata = bcast_i;
    endcase
  end

  assign mul_b = (op == OP_MAC8) ? {{(WORD_W-8){mem_byte[7]}}, mem_byte} : mem_word;

  node_regfile #(.DEPTH(REGS), .WIDTH(WORD_W)) u_rf (
    .clk     (clk),
    .we_i    (reg_we),
    .waddr_i (rd_i),
    .wdata_i (reg_wdata),
    .raddr_i (rs_i),
    .rdata_o (rs_data)
  );

  node_local_mem #(.BYTES(MEM_BYTES)) u_mem (
    .clk       (clk),
    .addr_i    (ptr_o),
    .wr_word_i (exec && (op == OP_STW)),
    .wr_byte_i (exec && (op == OP_STB)),
    .wdata_i   (rs_data),
    .word_o    (mem_word),
    .byte_o    (mem_byte)
  );

  node_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .adv_i  (adv),
    .load_i (load_ptr),
    .off_i  (addr_off_i),
    .ptr_o  (ptr_o)
  );

  node_mult_acc #(.A_W(BC_MUL_W), .B_W(WORD_W), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .hold_i  (spin_i),
    .clr_i   (clr),
    .issue_i (exec && is_mac),
    .a_i     (bcast_i[BC_MUL_W-1:0]),
    .b_i     (mul_b),
    .acc_o   (acc_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o)
  );

  assign reg_o = rs_data;
  assign mem_o = mem_word;
endmodule

// File: rtl/simd_node_mac_chk.sv
module simd_node_mac_chk
  import simd_mac_pkg::*;
(
  input logic        clk,
  input logic        rst_ok,
  input logic [3:0]  op_i,
  input logic [1:0]  cond_i,
  input logic [11:0] addr_off_i,
  input logic        spin_i,
  input logic [31:0] acc_o,
  input logic        zero_o,
  input logic        neg_o,
  input logic [11:0] ptr_o
);
  AST_FLAGS_MATCH_SUM: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_o == (acc_o == 32'd0)) && (neg_o == acc_o[31])); // R9

  AST_SPIN_FREEZES: assert property (@(posedge clk) disable iff (!rst_ok)
    spin_i |=> ($stable(acc_o) && $stable(ptr_o) && $stable(zero_o) && $stable(neg_o))); // R11

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ok)
    (!spin_i && op_i == OP_CLR && cond_i == CC_ALWAYS) |=> (acc_o == 32'd0)); // R8

  AST_PTR_LOADS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!spin_i && op_i == OP_SETP && cond_i == CC_ALWAYS) |=> (ptr_o == $past(addr_off_i))); // R4

  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!spin_i && op_i == OP_MAC16 && cond_i == CC_ALWAYS)
      |=> (ptr_o == 12'($past(ptr_o) + $past(addr_off_i)))); // R4

  AST_SKIPPED_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (!spin_i && cond_i == CC_ZERO && !zero_o) |=> $stable(ptr_o)); // R10
endmodule

bind simd_node_mac simd_node_mac_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_core_n),
  .op_i       (op_i),
  .cond_i     (cond_i),
  .addr_off_i (addr_off_i),
  .spin_i     (spin_i),
  .acc_o      (acc_o),
  .zero_o     (zero_o),
  .neg_o      (neg_o),
  .ptr_o      (ptr_o)
);

// File: tb/simd_node_mac_test.sv
module simd_node_mac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [4:0]  rs_i = '0, rd_i = '0;
  logic [1:0]  cond_i = '0;
  logic [11:0] addr_off_i = '0;
  logic [15:0] bcast_i = '0;
  logic        spin_i = 1'b0;
  logic [31:0] acc_o;
  logic        zero_o, neg_o;
  logic [11:0] ptr_o;
  logic [15:0] reg_o, mem_o;

  always #10 clk = ~clk;

  simd_node_mac uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rs_i(rs_i), .rd_i(rd_i),
    .cond_i(cond_i), .addr_off_i(addr_off_i), .bcast_i(bcast_i), .spin_i(spin_i),
    .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o), .ptr_o(ptr_o),
    .reg_o(reg_o), .mem_o(mem_o)
  );

  int    nvec = 0;
  int    nerr = 0;
  string cur_req = "R1";
  bit    comb_ok = 1'b0;

  bit [7:0]  mmem [4096];
  bit [15:0] mreg [32];
  bit [31:0] macc = '0, mpend = '0;
  bit        mpv = 1'b0, mz = 1'b1, mn = 1'b0;
  bit [11:0] mptr = '0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic step(input bit [3:0] op, input bit [4:0] rs, input bit [4:0] rd,
                      input bit [11:0] off, input bit [1:0] cc, input bit [15:0] bc,
                      input bit sp);
    bit        ok, ex;
    bit [11:0] wa, wb;
    bit [15:0] w;
    bit [7:0]  b8;
    op_i = op; rs_i = rs; rd_i = rd; addr_off_i = off; cond_i = cc; bcast_i = bc; spin_i = sp;
    #1;
    wa = {mptr[11:1], 1'b0};
    wb = {mptr[11:1], 1'b1};
    w  = {mmem[wb], mmem[wa]};
    b8 = mmem[mptr];
    if (comb_ok) begin
      chk("reg_o", 32'(reg_o), 32'(mreg[rs]));
      chk("mem_o", 32'(mem_o), 32'(w));
    end
    case (cc)
      2'd0: ok = 1'b1;
      2'd1: ok = mz;
      2'd2: ok = mn;
      default: ok = !mz;
    endcase
    ex = !sp && ok;
    if (!sp) begin
      if (ex && op == 4'd7) begin
        macc = '0; mz = 1'b1; mn = 1'b0; mpv = 1'b0;
      end else begin
        if (mpv) begin
          macc = macc + mpend;
          mz = (macc == 32'd0);
          mn = macc[31];
        end
        mpv = 1'b0;
        if (ex && (op == 4'd1 || op == 4'd2)) begin
          int a, m;
          a = int'($signed(bc[8:0]));
          m = (op == 4'd1) ? int'($signed(w)) : int'($signed(b8));
          mpend = a * m;
          mpv = 1'b1;
        end
      end
      if (ex) begin
        case (op)
          4'd3: mreg[rd] = w;
          4'd4: mreg[rd] = {8'h00, b8};
          4'd9: mreg[rd] = bc;
          4'd5: begin mmem[wa] = mreg[rs][7:0]; mmem[wb] = mreg[rs][15:8]; end
          4'd6: mmem[mptr] = mreg[rs][7:0];
          default: ;
        endcase
        if (op >= 4'd1 && op <= 4'd6) mptr = mptr + off;
        else if (op == 4'd8) mptr = off;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("acc_o", acc_o, macc);
    chk("ptr_o", 32'(ptr_o), 32'(mptr));
    chk("zero_o", 32'(zero_o), 32'(mz));
    chk("neg_o", 32'(neg_o), 32'(mn));
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(4'd0, 5'd0, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
  endtask

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk("acc in reset", acc_o, 32'd0);
    chk("ptr in reset", 32'(ptr_o), 32'd0);
    chk("zero in reset", 32'(zero_o), 32'd1);
    chk("neg in reset", 32'(neg_o), 32'd0);
    rst_n = 1'b1;
    nop(4);

    // Fill the whole memory with words through register 0 (R7, R5)
    cur_req = "R7";
    for (int i = 0; i < 2048; i++) begin
      step(4'd9, 5'd0, 5'd0, 12'd0, 2'd0, 16'(i * 40503) ^ 16'h5A5A, 1'b0);
      step(4'd5, 5'd0, 5'd0, 12'd2, 2'd0, 16'd0, 1'b0);
    end
    for (int r = 0; r < 32; r++) step(4'd9, 5'd0, 5'(r), 12'd0, 2'd0, 16'(r * 4951 + 7), 1'b0);
    comb_ok = 1'b1;
    for (int r = 0; r < 32; r++) step(4'd0, 5'(r), 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);

    // R5: unaligned word store lands on the even address, low byte first
    cur_req = "R5";
    step(4'd8, 5'd0, 5'd0, 12'h101, 2'd0, 16'd0, 1'b0);
    step(4'd9, 5'd0, 5'd1, 12'd0, 2'd0, 16'hBEEF, 1'b0);
    step(4'd5, 5'd1, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd3, 5'd1, 5'd2, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd0, 5'd2, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);

    // R6: byte load zero-extends, byte store touches one byte
    cur_req = "R6";
    step(4'd4, 5'd0, 5'd3, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd0, 5'd3, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd9, 5'd0, 5'd4, 12'd0, 2'd0, 16'h1281, 1'b0);
    step(4'd6, 5'd4, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd8, 5'd0, 5'd0, 12'h100, 2'd0, 16'd0, 1'b0);
    step(4'd6, 5'd4, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    nop(1);

    // R2: word multiply-accumulate with signed broadcast extremes
    cur_req = "R2";
    step(4'd7, 5'd0, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd1, 5'd0, 5'd0, 12'd0, 2'd0, 16'h00FF, 1'b0);
    step(4'd1, 5'd0, 5'd0, 12'd2, 2'd0, 16'hFF00, 1'b0);
    step(4'd1, 5'd0, 5'd0, 12'd2, 2'd0, 16'h01FF, 1'b0);
    nop(2);

    // R3: byte multiply-accumulate at odd and even addresses
    cur_req = "R3";
    step(4'd8, 5'd0, 5'd0, 12'h101, 2'd0, 16'd0, 1'b0);
    step(4'd2, 5'd0, 5'd0, 12'hFFF, 2'd0, 16'h0103, 1'b0);
    step(4'd2, 5'd0, 5'd0, 12'd0, 2'd0, 16'h007F, 1'b0);
    nop(2);

    // R8: clear drops the pending product
    cur_req = "R8";
    step(4'd1, 5'd0, 5'd0, 12'd0, 2'd0, 16'h0055, 1'b0);
    step(4'd7, 5'd0, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    nop(2);

    // R10 / R9: conditions on zero and sign
    cur_req = "R10";
    step(4'd1, 5'd0, 5'd0, 12'd6, 2'd1, 16'h0033, 1'b0);
    step(4'd9, 5'd0, 5'd5, 12'd0, 2'd3, 16'h7777, 1'b0);
    step(4'd0, 5'd5, 5'd0, 12'd0, 2'd0, 16'd0, 1'b0);
    step(4'd8, 5'd0, 5'd0, 12'h100, 2'd0, 16'd0, 1'b0);
    step(4'd1, 5'd0, 5'd0, 12'd0, 2'd0, 16'h01F0, 1'b0);
    step(4'd5, 5'd1, 5'd0, 12'd4, 2'd1, 16'd0, 1'b0);
    cur_req = "R9";
    nop(1);
    cur_req = "R10";
    step(4'd9, 5'd0, 5'd6, 12'd0, 2'd2, 16'h1357, 1'b0);
    step(4'd7, 5'd6, 5'd0, 12'd0, 2'd1, 16'd0, 1'b0);
    step(4'd8, 5'd0, 5'd0, 12'h300, 2'd3, 16'd0, 1'b0);
    nop(1);

    // R11: spin holds a pending product
    cur_req = "R11";
    step(4'd1, 5'd0, 5'd0, 12'd2, 2'd0, 16'h0011, 1'b0);
    step(4'd7, 5'd0, 5'd0, 12'd0, 2'd0, 16'd0, 1'b1);
    step(4'd9, 5'd0, 5'd7, 12'd0, 2'd0, 16'hAAAA, 1'b1);
    step(4'd8, 5'd7, 5'd0, 12'h010, 2'd0, 16'd0, 1'b1);
    nop(2);

    // R4: pointer wraps modulo 4096
    cur_req = "R4";
    step(4'd8, 5'd0, 5'd0, 12'hFFE, 2'd0, 16'd0, 1'b0);
    step(4'd1, 5'd0, 5'd0, 12'd5, 2'd0, 16'h0002, 1'b0);
    step(4'd3, 5'd0, 5'd8, 12'hFFD, 2'd0, 16'd0, 1'b0);
    nop(2);

    // Mixed run: all opcodes incl. 10..15, conditions and spin
    cur_req = "R2/R10/R11 mixed";
    for (int i = 0; i < 3000; i++) begin
      bit [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      step(rop, 5'($urandom), 5'($urandom), 12'($urandom), 2'($urandom),
           16'($urandom), ($urandom_range(0, 7) == 0));
    end
    nop(2);
    finish_run();
  end
endmodule